// File: doc/BRIEF.md
# Sampling Delay Window Finder

This block picks the delay tap a capture path should use once a sweep of its delay line has been recorded. Its input is a pass/fail map with one bit per tap. Bit i of the map is 1 when tap i sampled correctly. The block walks the map one tap per clock and keeps the longest unbroken run of passing taps. It then reports where that run starts, how long it is, and the tap inside it that should be programmed.

There are two operating modes. In single mode only the rising-edge map is examined. In dual mode the rising-edge result is judged first. If its margin is already good enough, the falling-edge map is never scanned. Otherwise the falling-edge map is scanned as well, and the edge with the wider window wins. A one-cycle start request launches the work. Both maps and the mode are captured at that moment. A one-cycle done pulse marks the cycle in which the result outputs change.

Top module: `tw_window_finder`

## Requirements
- R1: After reset, busy and done are 0, res_start is 0, res_len is 0, res_tap is 0xFF and res_fall is 0.
- R2: A map with no passing tap gives res_len 0, res_start 0 and res_tap 0xFF, which is the failure code.
- R3: The result is the longest run of consecutive 1 bits. Bit i is tap i, and a run ends at tap 31 without wrapping to tap 0. A later run replaces the kept one only when it is strictly longer, so the earliest of equally long runs is reported.
- R4: The scan ends early as soon as a run has just completed that is at least 12 taps long, while the kept run starts below tap 4. Runs further up the map are then not considered.
- R5: For a non-empty result, res_tap is res_len/3 when res_start is 0. Otherwise it is res_start + res_len/2 (integer division, modulo 32).
- R6: With dual_edge = 0, the result comes from rise_map alone, res_fall is 0, and fall_map has no effect.
- R7: With dual_edge = 1, the rising-edge result is reported with res_fall = 0, and fall_map has no effect, when that result is at least 12 long, or when it starts at tap 0 and is at least 4 long.
- R8: With dual_edge = 1 and the rising-edge result not sufficient, the falling-edge map is also scanned. The rising edge is reported (res_fall = 0) when its length is greater than or equal to the falling one. Otherwise the falling edge's start, length and tap are reported with res_fall = 1.
- R9: done is a single-cycle pulse. busy is 1 from the cycle after an accepted start until the result is published. A start while busy is ignored, and the result outputs hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted when not busy |
| dual_edge | input | 1 | 1 selects the rising/falling comparison mode |
| rise_map | input | 32 | Rising-edge pass map, bit i = tap i |
| fall_map | input | 32 | Falling-edge pass map, bit i = tap i |
| busy | output | 1 | A search is running |
| done | output | 1 | One-cycle pulse, results updated in this cycle |
| res_start | output | 5 | First tap of the reported window |
| res_len | output | 6 | Length of the reported window |
| res_tap | output | 8 | Chosen tap, 0xFF when no tap passed |
| res_fall | output | 1 | 1 when the falling edge was chosen |

## Verification
A corrupted run tracker shows at the ports as a wrong res_start or res_len at the very next done pulse, because every result is a pure function of the captured maps. A broken early-exit or skip decision is caught by maps whose later, longer run would change the answer. A broken edge comparison is caught by equal-length and longer-falling cases. A stuck phase register shows as done never pulsing, or pulsing twice, within the 70-cycle worst-case search. A leak of new inputs into a running search shows as a result that differs from the first request's maps.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RISE = 2'd1,
      PH_FALL = 2'd2
   } tw_phase_e;
endpackage

// File: rtl/tw_run_scan.sv
module tw_run_scan #(
   parameter int NUM_TAPS    = 32,
   parameter int LONG_RUN    = 12,
   parameter int EARLY_START = 4,
   parameter bit EARLY_EXIT  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        go,
   input  logic [NUM_TAPS-1:0]         map,
   output logic                        active,
   output logic                        fin,
   output logic [$clog2(NUM_TAPS)-1:0] best_start,
   output logic [$clog2(NUM_TAPS):0]   best_len
);
   localparam int TAP_W = $clog2(NUM_TAPS);
   localparam int LEN_W = TAP_W + 1;
   localparam logic [TAP_W-1:0] LAST_POS = TAP_W'(NUM_TAPS - 1);
   localparam logic [LEN_W-1:0] LONG_C   = LEN_W'(LONG_RUN);
   localparam logic [LEN_W-1:0] ESTART_C = LEN_W'(EARLY_START);

   logic [TAP_W-1:0] pos;
   logic [TAP_W-1:0] cur_start;
   logic [LEN_W-1:0] cur_len;

   logic             bit_now;
   logic [LEN_W-1:0] run_len_now;
   logic [TAP_W-1:0] run_st_now;
   logic             at_last;
   logic             run_end;
   logic             take;
   logic [TAP_W-1:0] best_st_next;
   logic             stop_hit;

   always_comb begin
      bit_now      = map[pos];
      run_len_now  = bit_now ? cur_len + LEN_W'(1) : cur_len;
      run_st_now   = (bit_now && cur_len == '0) ? pos : cur_start;
      at_last      = (pos == LAST_POS);
      run_end      = !bit_now || at_last;
      take         = run_end && (run_len_now > best_len);
      best_st_next = take ? run_st_now : best_start;
   end

   generate
      if (EARLY_EXIT) begin : g_early
         assign stop_hit = run_end && (run_len_now >= LONG_C) &&
                           ({1'b0, best_st_next} < ESTART_C);
      end else begin : g_full
         assign stop_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         fin        <= 1'b0;
         pos        <= '0;
         cur_start  <= '0;
         cur_len    <= '0;
         best_start <= '0;
         best_len   <= '0;
      end else begin
         fin <= 1'b0;
         if (!active) begin
            if (go) begin
               active     <= 1'b1;
               pos        <= '0;
               cur_start  <= '0;
               cur_len    <= '0;
               best_start <= '0;
               best_len   <= '0;
            end
         end else begin
            if (take) begin
               best_start <= run_st_now;
               best_len   <= run_len_now;
            end
            if (bit_now) begin
               cur_start <= run_st_now;
               cur_len   <= run_len_now;
            end else begin
               cur_len <= '0;
            end
            if (at_last || stop_hit) begin
               active <= 1'b0;
               fin    <= 1'b1;
            end else begin
               pos <= pos + TAP_W'(1);
            end
         end
      end
   end

   AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> (best_len >= $past(best_len))); // R3
   AST_RUN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ((LEN_W+1)'(cur_start) + (LEN_W+1)'(cur_len) <= (LEN_W+1)'(NUM_TAPS))); // R3
endmodule

// File: rtl/tw_tap_pick.sv
module tw_tap_pick #(
   parameter int NUM_TAPS = 32,
   parameter int OUT_W    = 8,
   parameter logic [OUT_W-1:0] FAIL_CODE = '1
) (
   input  logic [$clog2(NUM_TAPS)-1:0] win_start,
   input  logic [$clog2(NUM_TAPS):0]   win_len,
   output logic [OUT_W-1:0]            tap
);
   localparam int TAP_W = $clog2(NUM_TAPS);
   localparam int LEN_W = TAP_W + 1;

   logic [LEN_W-1:0] third;
   logic [TAP_W-1:0] middle;

   always_comb begin
      third  = win_len / LEN_W'(3);
      middle = win_start + TAP_W'(win_len >> 1);
      if (win_len == '0)
         tap = FAIL_CODE;
      else if (win_start == '0)
         tap = OUT_W'(third);
      else
         tap = OUT_W'(middle);
   end
endmodule

// File: rtl/tw_window_finder.sv
module tw_window_finder #(
   parameter int NUM_TAPS       = 32,
   parameter int LONG_RUN       = 12,
   parameter int EARLY_START    = 4,
   parameter int ZERO_START_MIN = 4,
   parameter bit EARLY_EXIT     = 1'b1,
   parameter logic [7:0] FAIL_CODE = 8'hFF
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        dual_edge,
   input  logic [NUM_TAPS-1:0]         rise_map,
   input  logic [NUM_TAPS-1:0]         fall_map,
   output logic                        busy,
   output logic                        done,
   output logic [$clog2(NUM_TAPS)-1:0] res_start,
   output logic [$clog2(NUM_TAPS):0]   res_len,
   output logic [7:0]                  res_tap,
   output logic                        res_fall
);
   import tw_pkg::*;

   localparam int TAP_W = $clog2(NUM_TAPS);
   localparam int LEN_W = TAP_W + 1;
   localparam logic [LEN_W-1:0] LONG_C = LEN_W'(LONG_RUN);
   localparam logic [LEN_W-1:0] ZMIN_C = LEN_W'(ZERO_START_MIN);

   generate
      if (NUM_TAPS < 2 || (1 << TAP_W) != NUM_TAPS) begin : g_bad_taps
         $error("tw_window_finder: NUM_TAPS must be a power of two >= 2");
      end
      if (TAP_W > 7) begin : g_bad_code
         $error("tw_window_finder: taps must fit below the 8-bit fail code");
      end
      if (LONG_RUN < 1 || LONG_RUN > NUM_TAPS || ZERO_START_MIN > NUM_TAPS) begin : g_bad_run
         $error("tw_window_finder: run thresholds out of range");
      end
   endgenerate

   tw_phase_e        phase;
   logic [NUM_TAPS-1:0] map_r, map_f;
   logic             dual_q;
   logic             kick;
   logic [TAP_W-1:0] rise_st_q;
   logic [LEN_W-1:0] rise_len_q;

   logic             sc_active, sc_fin;
   logic [TAP_W-1:0] sc_st;
   logic [LEN_W-1:0] sc_len;
   logic [7:0]       sc_tap, rise_tap;
   logic             rise_ok;

   tw_run_scan #(
      .NUM_TAPS(NUM_TAPS), .LONG_RUN(LONG_RUN),
      .EARLY_START(EARLY_START), .EARLY_EXIT(EARLY_EXIT)
   ) u_scan (
      .clk(clk), .rst_n(rst_n), .go(kick),
      .map((phase == PH_FALL) ? map_f : map_r),
      .active(sc_active), .fin(sc_fin),
      .best_start(sc_st), .best_len(sc_len)
   );

   tw_tap_pick #(.NUM_TAPS(NUM_TAPS), .OUT_W(8), .FAIL_CODE(FAIL_CODE)) u_pick_scan (
      .win_start(sc_st), .win_len(sc_len), .tap(sc_tap)
   );

   tw_tap_pick #(.NUM_TAPS(NUM_TAPS), .OUT_W(8), .FAIL_CODE(FAIL_CODE)) u_pick_rise (
      .win_start(rise_st_q), .win_len(rise_len_q), .tap(rise_tap)
   );

   assign rise_ok = (sc_len >= LONG_C) || (sc_st == '0 && sc_len >= ZMIN_C);
   assign busy    = (phase != PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         map_r      <= '0;
         map_f      <= '0;
         dual_q     <= 1'b0;
         kick       <= 1'b0;
         done       <= 1'b0;
         rise_st_q  <= '0;
         rise_len_q <= '0;
         res_start  <= '0;
         res_len    <= '0;
         res_tap    <= FAIL_CODE;
         res_fall   <= 1'b0;
      end else begin
         kick <= 1'b0;
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  map_r  <= rise_map;
                  map_f  <= fall_map;
                  dual_q <= dual_edge;
                  kick   <= 1'b1;
                  phase  <= PH_RISE;
               end
            end
            PH_RISE: begin
               if (sc_fin) begin
                  if (!dual_q || rise_ok) begin
                     res_start <= sc_st;
                     res_len   <= sc_len;
                     res_tap   <= sc_tap;
                     res_fall  <= 1'b0;
                     done      <= 1'b1;
                     phase     <= PH_IDLE;
                  end else begin
                     rise_st_q  <= sc_st;
                     rise_len_q <= sc_len;
                     kick       <= 1'b1;
                     phase      <= PH_FALL;
                  end
               end
            end
            PH_FALL: begin
               if (sc_fin) begin
                  if (rise_len_q >= sc_len) begin
                     res_start <= rise_st_q;
                     res_len   <= rise_len_q;
                     res_tap   <= rise_tap;
                     res_fall  <= 1'b0;
                  end else begin
                     res_start <= sc_st;
                     res_len   <= sc_len;
                     res_tap   <= sc_tap;
                     res_fall  <= 1'b1;
                  end
                  done  <= 1'b1;
                  phase <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({res_start, res_len, res_tap, res_fall})); // R9
   AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_len == '0) |-> (res_tap == FAIL_CODE)); // R2
   AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_len != '0) |-> (res_tap < 8'(NUM_TAPS))); // R5
   AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !dual_q) |-> !res_fall); // R6
   AST_SKIP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_fall) |-> !(rise_len_q >= LONG_C || (rise_st_q == '0 && rise_len_q >= ZMIN_C))); // R7
   AST_FALL_LONGER: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_fall) |-> (res_len > rise_len_q)); // R8
endmodule

// File: tb/sim_tw_window_finder.sv
module sim_tw_window_finder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dual_edge = 1'b0;
   logic [31:0] rise_map = '0;
   logic [31:0] fall_map = '0;
   logic        busy, done, res_fall;
   logic [4:0]  res_start;
   logic [5:0]  res_len;
   logic [7:0]  res_tap;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   tw_window_finder u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .dual_edge(dual_edge),
      .rise_map(rise_map), .fall_map(fall_map), .busy(busy), .done(done),
      .res_start(res_start), .res_len(res_len), .res_tap(res_tap), .res_fall(res_fall)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void ref_scan(input logic [31:0] m, output int st, output int ln);
      int s, l;
      s = 0; st = 0; ln = 0;
      while (s < 32) begin
         l = 0;
         while (s + l < 32 && m[s+l]) l++;
         if (ln < l) begin st = s; ln = l; end
         s += (l != 0) ? l : 1;
         if (l >= 12 && st < 4) break;
      end
   endfunction

   function automatic int ref_tap(input int st, input int ln);
      if (ln == 0) return 255;
      if (st == 0) return ln / 3;
      return (st + ln / 2) % 32;
   endfunction

   function automatic void ref_all(input logic [31:0] r, input logic [31:0] f, input bit dual,
                                   output int st, output int ln, output int tp, output int fe);
      int rs, rl, fs, fl;
      ref_scan(r, rs, rl);
      st = rs; ln = rl; fe = 0;
      if (dual && !(rl >= 12 || (rs == 0 && rl >= 4))) begin
         ref_scan(f, fs, fl);
         if (fl > rl) begin st = fs; ln = fl; fe = 1; end
      end
      tp = ref_tap(st, ln);
   endfunction

   task automatic wait_done(input string req);
      int n;
      n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      check(req, "done seen", int'(done), 1);
   endtask

   task automatic run_case(input string req, input logic [31:0] r, input logic [31:0] f, input bit dual);
      int st, ln, tp, fe;
      ref_all(r, f, dual, st, ln, tp, fe);
      @(negedge clk);
      rise_map = r; fall_map = f; dual_edge = dual; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(req);
      check(req, "res_start", int'(res_start), st);
      check(req, "res_len", int'(res_len), ln);
      check(req, "res_tap", int'(res_tap), tp);
      check(req, "res_fall", int'(res_fall), fe);
      @(negedge clk);
      check("R9", "done single pulse", int'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] a, b;
      int st, ln, tp, fe;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "busy", int'(busy), 0);
      check("R1", "done", int'(done), 0);
      check("R1", "res_tap", int'(res_tap), 255);
      check("R1", "res_len", int'(res_len), 0);
      check("R1", "res_fall", int'(res_fall), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_case("R2", 32'h0000_0000, 32'h0000_0000, 1'b0);
      run_case("R2", 32'h0000_0000, 32'h0000_0000, 1'b1);
      run_case("R5", 32'hFFFF_FFFF, 32'h0, 1'b0);            // 0/32 -> tap 10
      run_case("R3", 32'h8000_0000, 32'h0, 1'b0);            // 31/1 no wrap
      run_case("R3", 32'h8000_0001, 32'h0, 1'b0);            // tie, earlier wins
      run_case("R3", 32'h00F0_00F0, 32'h0, 1'b0);            // tie at 4 and 20
      run_case("R4", 32'h1FFF_CFFF, 32'h0, 1'b0);            // stops at 0/12
      run_case("R4", 32'hFFFC_FFF0, 32'h0, 1'b0);            // start 4 does not stop
      run_case("R5", 32'h0000_3F00, 32'h0, 1'b0);            // 8/6 -> 11
      run_case("R6", 32'h0000_0070, 32'hFFFF_FFFF, 1'b0);    // fall map unused
      run_case("R7", 32'h0000_000F, 32'hFFFF_FFFF, 1'b1);    // 0/4 enough
      run_case("R7", 32'h000F_FF00, 32'hFFFF_FFFF, 1'b1);    // 8/12 enough
      run_case("R8", 32'h0000_0070, 32'h0003_FC00, 1'b1);    // falling wins
      run_case("R8", 32'h0000_0070, 32'h0000_7000, 1'b1);    // tie -> rising
      run_case("R8", 32'h0000_0000, 32'h0000_0006, 1'b1);    // rising empty

      // R9: start while busy is ignored, outputs hold after done
      ref_all(32'h0000_0FF0, 32'h0, 1'b0, st, ln, tp, fe);
      @(negedge clk);
      rise_map = 32'h0000_0FF0; fall_map = '0; dual_edge = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      check("R9", "busy mid-scan", int'(busy), 1);
      rise_map = 32'hFFFF_FFFF; dual_edge = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R9");
      check("R9", "res_len after ignored start", int'(res_len), ln);
      check("R9", "res_tap after ignored start", int'(res_tap), tp);
      repeat (3) @(negedge clk);
      check("R9", "busy after done", int'(busy), 0);
      check("R9", "res_len held", int'(res_len), ln);
      check("R9", "res_start held", int'(res_start), st);

      // sweep of generated maps, both modes (R3 R4 R5 R7 R8)
      a = 32'h1234_5678; b = 32'h9ABC_DEF1;
      for (int k = 0; k < 300; k++) begin
         a = {a[30:0], a[31] ^ a[21] ^ a[1] ^ a[0]};
         b = {b[30:0], b[31] ^ b[21] ^ b[1] ^ b[0]};
         run_case("R3", a | (a >> (k % 5)), b & (b << (k % 3)), k[0]);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule